// File: doc/BRIEF.md
# Throttled Four-Channel DMA Loop Sequencer

This block steps one DMA channel at a time through its minor loop. A minor loop is a run of transfers, and each transfer is a read access followed by a write access. Every access is a one-cycle strobe on the bus request outputs. After each access the engine can hold the bus request low for a fixed number of idle cycles. This lets software trade transfer speed for bus bandwidth. When the source and destination sizes are equal, two of those idle gaps are dropped to cut start-up and wind-down latency.

Each channel keeps a pending-start flag, a major loop counter and a done flag. Finishing a minor loop uses up one major iteration. When the last major iteration completes, the channel raises done. It can then optionally set the start flag of another channel, so several channels can be chained without software help. Addresses, interrupts and fair arbitration are left to the surrounding logic. A fixed scan order decides which pending channel runs next.

Top module: `dma_thr_engine`

## Requirements
- R1: While reset is held and after it is released, `bus_rd`, `bus_wr`, `ch_done` and `ch_active` are all zero.
- R2: A minor loop for channel c with transfer count N issues 2N one-cycle access strobes. They alternate read, write, read, write, starting with `bus_rd`, and `bus_ch` equals c on every strobe. A programmed count of 0 behaves as 1.
- R3: The throttle code of a channel (2 bits per channel, channel c at bits [2c+1:2c]) selects the idle gap that follows an access: 2'b00 gives 0 cycles, 2'b10 gives 4 cycles and 2'b11 gives 8 cycles. During a gap both strobes are low.
- R4: Throttle code 2'b01 behaves exactly like 2'b00.
- R5: With the size-equal bit set, no gap follows the first access of the loop (the read of the first transfer), and no gap follows the final write. All other accesses keep the gap of R3.
- R6: A start flag becomes set at clock edge k while the engine is idle. The channel's first read strobe is then present in the cycle after edge k+1.
- R7: `ch_active[c]` is high from the cycle of the first access of a loop through the last access or gap cycle of that loop. It is low in every other cycle.
- R8: When a loop starts with the channel's major counter at zero, the counter loads the programmed major count (0 behaves as 1). Each finished loop decrements the counter. `ch_done[c]` goes high in the cycle after the loop that brings the counter to zero, and it clears when the channel next begins a loop.
- R9: At the end of a loop that exhausts the major count, if the channel's link enable is 1, the start flag of the channel named by its 2-bit link field is set. That channel then follows R6. With link enable 0, no further loop starts.
- R10: When the engine is idle, the pending channel with the lowest index is served first. A start request that arrives while another channel runs stays pending until it is served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_bwc | input | 2*NCH | Per-channel throttle code |
| cfg_link_en | input | NCH | Per-channel link enable |
| cfg_link_ch | input | CHW*NCH | Per-channel link target index |
| cfg_minor | input | MINW*NCH | Per-channel transfers per minor loop |
| cfg_major | input | MAJW*NCH | Per-channel major loop count |
| cfg_size_eq | input | NCH | Per-channel source/destination size equal |
| start_set | input | NCH | One-cycle pulse that sets a channel's start flag |
| bus_rd | output | 1 | Read access strobe |
| bus_wr | output | 1 | Write access strobe |
| bus_ch | output | CHW | Channel owning the current access |
| ch_done | output | NCH | Per-channel major loop done flag |
| ch_active | output | NCH | Per-channel minor loop running flag |

## Verification
The bench keeps the default build: four channels, 4-bit minor and major counts, and gaps of 4 and 8 cycles. With those values it can sweep all four throttle codes, both size-equal settings and minor counts 0 to 3. For each run it predicts, from the gap rule alone, the exact cycle of every strobe, the span of the active flag and the done edge. The small major count lets it walk a channel through three iterations and a restart. Four channels are enough to exercise a link to a different channel, a link left disabled, and two simultaneous start requests.

// File: rtl/dma_thr_pkg.sv
// Package: shared state encoding and throttle decode for the DMA loop sequencer.
// Assumes a 2-bit throttle code in which the two low-rate codes mean "no gap".
package dma_thr_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_ACC   = 2'd1,
        SQ_STALL = 2'd2
    } sq_state_e;

    localparam logic [1:0] THR_NONE = 2'b00;
    localparam logic [1:0] THR_RSVD = 2'b01;
    localparam logic [1:0] THR_MID  = 2'b10;
    localparam logic [1:0] THR_HIGH = 2'b11;

    // Map a throttle code to the number of idle cycles after an access.
    function automatic int unsigned gap_cycles(input logic [1:0] code,
                                               input int unsigned mid_len,
                                               input int unsigned high_len);
        case (code)
            THR_MID:  return mid_len;
            THR_HIGH: return high_len;
            default:  return 0;
        endcase
    endfunction

endpackage

// File: rtl/dma_loop_seq.sv
// Module: dma_loop_seq
// Runs one minor loop at a time: alternating read and write strobes, each one
// optionally followed by an idle gap taken from the latched throttle code.
// Assumes `go` is only raised while `busy` is low; the loop parameters are
// sampled on that cycle and held until the loop ends.
module dma_loop_seq
    import dma_thr_pkg::*;
#(
    parameter int NCH       = 4,
    parameter int MINW      = 4,
    parameter int STALL_MID = 4,
    parameter int STALL_HI  = 8,
    localparam int CHW      = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int ACCW     = MINW + 1,
    localparam int STW      = $clog2(STALL_HI + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            go,
    input  logic [CHW-1:0]  go_ch,
    input  logic [MINW-1:0] go_minor,
    input  logic [1:0]      go_bwc,
    input  logic            go_eq,
    output logic            busy,
    output logic            acc_rd,
    output logic            acc_wr,
    output logic [CHW-1:0]  acc_ch,
    output logic            loop_end
);

    sq_state_e       st_q;
    logic [CHW-1:0]  ch_q;
    logic [ACCW-1:0] left_q;
    logic            first_q;
    logic [1:0]      bwc_q;
    logic            eq_q;
    logic [STW-1:0]  stall_q;

    logic [MINW-1:0] eff_minor;
    logic [STW-1:0]  gap_len;
    logic            is_last;
    logic            take_gap;

    // Decode the per-access gap decision from the latched loop settings.
    always_comb begin
        eff_minor = (go_minor == '0) ? MINW'(1) : go_minor;
        gap_len   = STW'(gap_cycles(bwc_q, STALL_MID, STALL_HI));
        is_last   = (left_q == ACCW'(1));
        take_gap  = (gap_len != '0) && !(eq_q && (first_q || is_last));
    end

    // Loop state machine: latch settings, step accesses, count gaps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= SQ_IDLE;
            ch_q    <= '0;
            left_q  <= '0;
            first_q <= 1'b0;
            bwc_q   <= '0;
            eq_q    <= 1'b0;
            stall_q <= '0;
        end else begin
            case (st_q)
                SQ_IDLE: begin
                    if (go) begin
                        st_q    <= SQ_ACC;
                        ch_q    <= go_ch;
                        left_q  <= {eff_minor, 1'b0};
                        first_q <= 1'b1;
                        bwc_q   <= go_bwc;
                        eq_q    <= go_eq;
                    end
                end
                SQ_ACC: begin
                    left_q  <= left_q - ACCW'(1);
                    first_q <= 1'b0;
                    if (take_gap) begin
                        st_q    <= SQ_STALL;
                        stall_q <= gap_len - STW'(1);
                    end else if (is_last) begin
                        st_q <= SQ_IDLE;
                    end
                end
                SQ_STALL: begin
                    if (stall_q == '0) begin
                        st_q <= (left_q == '0) ? SQ_IDLE : SQ_ACC;
                    end else begin
                        stall_q <= stall_q - STW'(1);
                    end
                end
                default: st_q <= SQ_IDLE;
            endcase
        end
    end

    // Drive strobes and the loop completion pulse from the current state.
    always_comb begin
        busy     = (st_q != SQ_IDLE);
        acc_rd   = (st_q == SQ_ACC) && !left_q[0];
        acc_wr   = (st_q == SQ_ACC) && left_q[0];
        acc_ch   = ch_q;
        loop_end = ((st_q == SQ_ACC) && is_last && !take_gap) ||
                   ((st_q == SQ_STALL) && (stall_q == '0) && (left_q == '0));
    end

    // R2: a read is never followed directly by another read
    a_r2_no_double_read: assert property (@(posedge clk) disable iff (!rst_n)
        acc_rd |=> !acc_rd);

    // R3: the gap counter never exceeds the longest programmed gap
    a_r3_gap_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SQ_STALL) |-> (stall_q < STW'(STALL_HI)));

    // R5: with equal sizes the first access is followed at once by the next
    a_r5_first_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SQ_ACC && first_q && eq_q) |=> (st_q == SQ_ACC));

endmodule

// File: rtl/dma_chan_ctx.sv
// Module: dma_chan_ctx
// Per-channel context: pending start flag, major iteration counter and done
// flag. Assumes `grant` and `loop_end_me` never coincide, since a channel is
// granted only while the sequencer is idle.
module dma_chan_ctx #(
    parameter int MAJW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            set_req,
    input  logic            grant,
    input  logic            loop_end_me,
    input  logic [MAJW-1:0] cfg_major,
    output logic            start_q,
    output logic            done_q,
    output logic            exhaust
);

    logic [MAJW-1:0] major_q;
    logic [MAJW-1:0] eff_major;

    // Effective major count and the exhaust pulse on the final iteration.
    always_comb begin
        eff_major = (cfg_major == '0) ? MAJW'(1) : cfg_major;
        exhaust   = loop_end_me && (major_q == MAJW'(1));
    end

    // Start flag: set by request (wins), cleared when the channel is granted.
    always_ff @(posedge clk) begin
        if (!rst_n) start_q <= 1'b0;
        else        start_q <= set_req | (start_q & ~grant);
    end

    // Major counter: reload on a fresh start, decrement per finished loop.
    always_ff @(posedge clk) begin
        if (!rst_n)                             major_q <= '0;
        else if (grant && major_q == '0)        major_q <= eff_major;
        else if (loop_end_me)                   major_q <= major_q - MAJW'(1);
    end

    // Done flag: raised on exhaustion, dropped when the channel restarts.
    always_ff @(posedge clk) begin
        if (!rst_n)       done_q <= 1'b0;
        else if (grant)   done_q <= 1'b0;
        else if (exhaust) done_q <= 1'b1;
    end

    // R8: a loop never completes with an unloaded major counter
    a_r8_counter_loaded: assert property (@(posedge clk) disable iff (!rst_n)
        loop_end_me |-> (major_q != '0));

    // R8: exhausting the major count raises done on the next cycle
    a_r8_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
        exhaust |=> done_q);

    // R10: an ungranted pending start is held
    a_r10_start_held: assert property (@(posedge clk) disable iff (!rst_n)
        (start_q && !grant) |=> start_q);

endmodule

// File: rtl/dma_thr_engine.sv
// Module: dma_thr_engine
// Top of the throttled DMA loop sequencer. Holds one context per channel,
// picks the lowest-index pending channel while the sequencer is idle, and
// turns major-loop exhaustion into a start request on the linked channel.
// Assumes configuration inputs are stable while their channel runs.
module dma_thr_engine
    import dma_thr_pkg::*;
#(
    parameter int NCH       = 4,
    parameter int MINW      = 4,
    parameter int MAJW      = 4,
    parameter int STALL_MID = 4,
    parameter int STALL_HI  = 8,
    localparam int CHW      = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2*NCH-1:0]    cfg_bwc,
    input  logic [NCH-1:0]      cfg_link_en,
    input  logic [CHW*NCH-1:0]  cfg_link_ch,
    input  logic [MINW*NCH-1:0] cfg_minor,
    input  logic [MAJW*NCH-1:0] cfg_major,
    input  logic [NCH-1:0]      cfg_size_eq,
    input  logic [NCH-1:0]      start_set,
    output logic                bus_rd,
    output logic                bus_wr,
    output logic [CHW-1:0]      bus_ch,
    output logic [NCH-1:0]      ch_done,
    output logic [NCH-1:0]      ch_active
);

    logic [1:0]      bwc_a   [NCH];
    logic [CHW-1:0]  link_a  [NCH];
    logic [MINW-1:0] minor_a [NCH];

    logic [NCH-1:0]  pend;
    logic [NCH-1:0]  grant;
    logic [NCH-1:0]  set_req;
    logic [NCH-1:0]  exh;
    logic [NCH-1:0]  end_me;
    logic [CHW-1:0]  pick;
    logic            go;
    logic            busy;
    logic            loop_end;
    logic [CHW-1:0]  run_ch;
    logic            link_fire;
    logic [CHW-1:0]  link_tgt;

    // Per-channel slicing of configuration, start/link merge and context.
    for (genvar k = 0; k < NCH; k++) begin : g_ch
        assign bwc_a[k]   = cfg_bwc[2*k +: 2];
        assign link_a[k]  = cfg_link_ch[CHW*k +: CHW];
        assign minor_a[k] = cfg_minor[MINW*k +: MINW];
        assign set_req[k] = start_set[k] | (link_fire && (link_tgt == CHW'(k)));
        assign end_me[k]  = loop_end && (run_ch == CHW'(k));
        assign ch_active[k] = busy && (run_ch == CHW'(k));

        dma_chan_ctx #(.MAJW(MAJW)) u_ctx (
            .clk         (clk),
            .rst_n       (rst_n),
            .set_req     (set_req[k]),
            .grant       (grant[k]),
            .loop_end_me (end_me[k]),
            .cfg_major   (cfg_major[MAJW*k +: MAJW]),
            .start_q     (pend[k]),
            .done_q      (ch_done[k]),
            .exhaust     (exh[k])
        );
    end

    // Fixed scan order: lowest pending index wins while the sequencer idles.
    always_comb begin
        pick = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (pend[i]) pick = CHW'(i);
        end
        go    = (|pend) && !busy;
        grant = go ? (NCH'(1) << pick) : '0;
    end

    // Link request toward the target of the channel that just exhausted.
    always_comb begin
        link_fire = (|exh) && cfg_link_en[run_ch];
        link_tgt  = link_a[run_ch];
    end

    dma_loop_seq #(
        .NCH       (NCH),
        .MINW      (MINW),
        .STALL_MID (STALL_MID),
        .STALL_HI  (STALL_HI)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (go),
        .go_ch    (pick),
        .go_minor (minor_a[pick]),
        .go_bwc   (bwc_a[pick]),
        .go_eq    (cfg_size_eq[pick]),
        .busy     (busy),
        .acc_rd   (bus_rd),
        .acc_wr   (bus_wr),
        .acc_ch   (run_ch),
        .loop_end (loop_end)
    );

    assign bus_ch = run_ch;

    // R2: read and write strobes are never raised together
    a_r2_strobe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));

    // R6: a granted channel issues its first read on the next cycle
    a_r6_grant_to_read: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> (bus_rd && bus_ch == $past(pick)));

    // R7: at most one channel is marked active
    a_r7_single_active: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_active));

endmodule

// File: tb/tb_dma_thr_engine.sv
// Bench: sweeps throttle code, size-equal and minor count on one channel, then
// checks major counting, linking and scan order; expectations are computed
// from the gap rule in the requirements.
module tb_dma_thr_engine;

    localparam int NCH  = 4;
    localparam int CHW  = 2;
    localparam int MINW = 4;
    localparam int MAJW = 4;

    logic                clk = 1'b0;
    logic                rst_n;
    logic [2*NCH-1:0]    cfg_bwc;
    logic [NCH-1:0]      cfg_link_en;
    logic [CHW*NCH-1:0]  cfg_link_ch;
    logic [MINW*NCH-1:0] cfg_minor;
    logic [MAJW*NCH-1:0] cfg_major;
    logic [NCH-1:0]      cfg_size_eq;
    logic [NCH-1:0]      start_set;
    logic                bus_rd;
    logic                bus_wr;
    logic [CHW-1:0]      bus_ch;
    logic [NCH-1:0]      ch_done;
    logic [NCH-1:0]      ch_active;

    int vectors = 0;
    int errors  = 0;

    always #5 clk = ~clk;

    dma_thr_engine dut (
        .clk(clk), .rst_n(rst_n), .cfg_bwc(cfg_bwc), .cfg_link_en(cfg_link_en),
        .cfg_link_ch(cfg_link_ch), .cfg_minor(cfg_minor), .cfg_major(cfg_major),
        .cfg_size_eq(cfg_size_eq), .start_set(start_set), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_ch(bus_ch), .ch_done(ch_done), .ch_active(ch_active)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic set_cfg(input int c, input int bw, input int le, input int lc,
                           input int mn, input int mj, input int eq);
        cfg_bwc[2*c +: 2]        = bw[1:0];
        cfg_link_en[c]           = le[0];
        cfg_link_ch[CHW*c +: CHW] = lc[CHW-1:0];
        cfg_minor[MINW*c +: MINW] = mn[MINW-1:0];
        cfg_major[MAJW*c +: MAJW] = mj[MAJW-1:0];
        cfg_size_eq[c]           = eq[0];
    endtask

    function automatic int gap_of(input int bw, input int eq, input int i, input int n2);
        int s;
        s = (bw == 2) ? 4 : (bw == 3) ? 8 : 0;
        if (eq != 0 && (i == 0 || i == n2 - 1)) return 0;
        return s;
    endfunction

    // Sample 0 is the negedge with the start flag already set and the engine idle.
    task automatic do_loop(input int c, input int mn, input int bw, input int eq,
                           input bit exp_done, input bit pulse, input string tag);
        int t[64];
        int n2;
        int last_end;
        n2 = 2 * ((mn == 0) ? 1 : mn);
        t[0] = 1;
        for (int i = 0; i < n2 - 1; i++) t[i+1] = t[i] + 1 + gap_of(bw, eq, i, n2);
        last_end = t[n2-1] + gap_of(bw, eq, n2 - 1, n2);
        if (pulse) begin
            start_set[c] = 1'b1;
            @(negedge clk);
            start_set[c] = 1'b0;
        end
        for (int s = 0; s <= last_end + 1; s++) begin
            int e_rd;
            int e_wr;
            int e_act;
            int got;
            int want;
            if (s > 0) @(negedge clk);
            e_rd = 0;
            e_wr = 0;
            for (int i = 0; i < n2; i++) begin
                if (t[i] == s) begin
                    if (i % 2 == 0) e_rd = 1;
                    else            e_wr = 1;
                end
            end
            e_act = (s >= 1 && s <= last_end) ? 1 : 0;
            got  = {29'd0, bus_rd, bus_wr, ch_active[c]};
            want = (e_rd << 2) | (e_wr << 1) | e_act;
            if ((e_rd | e_wr) != 0 && int'(bus_ch) != c) got = got | 8;
            check(got == want, tag, got, want);
            if (s == 1) check(ch_done[c] == 1'b0, "R8 done clears on restart", ch_done[c], 0);
        end
        check(ch_done[c] == exp_done, "R8 done after loop", ch_done[c], exp_done);
    endtask

    initial begin
        rst_n = 1'b0;
        cfg_bwc = '0; cfg_link_en = '0; cfg_link_ch = '0;
        cfg_minor = '0; cfg_major = '0; cfg_size_eq = '0; start_set = '0;
        repeat (3) @(negedge clk);
        check({bus_rd, bus_wr} == 2'b00, "R1 strobes in reset", {bus_rd, bus_wr}, 0);
        check(ch_done == '0 && ch_active == '0, "R1 flags in reset", {ch_done, ch_active}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(ch_done == '0 && ch_active == '0 && !bus_rd && !bus_wr,
              "R1 idle after reset", {ch_done, ch_active}, 0);

        // R2 R3 R4 R5 R6 R7: sweep throttle, size-equal and minor count on channel 0
        for (int bw = 0; bw < 4; bw++) begin
            for (int eq = 0; eq < 2; eq++) begin
                for (int mn = 0; mn < 4; mn++) begin
                    string tag;
                    tag = (bw == 1) ? "R4 (R2 R6 R7)" : (eq != 0) ? "R5 (R2 R6 R7)" : "R3 (R2 R6 R7)";
                    set_cfg(0, bw, 0, 0, mn, 1, eq);
                    do_loop(0, mn, bw, eq, 1'b1, 1'b1, tag);
                    @(negedge clk);
                end
            end
        end

        // R8: three major iterations, then a restart that reloads
        set_cfg(1, 2, 0, 0, 1, 3, 0);
        do_loop(1, 1, 2, 0, 1'b0, 1'b1, "R8 iteration 1");
        do_loop(1, 1, 2, 0, 1'b0, 1'b1, "R8 iteration 2");
        do_loop(1, 1, 2, 0, 1'b1, 1'b1, "R8 iteration 3");
        @(negedge clk);
        check(ch_done[1] == 1'b1, "R8 done holds", ch_done[1], 1);
        do_loop(1, 1, 2, 0, 1'b0, 1'b1, "R8 restart");

        // R9: channel 0 links to channel 2
        set_cfg(0, 0, 1, 2, 2, 1, 0);
        set_cfg(2, 3, 0, 0, 1, 1, 1);
        @(negedge clk);
        do_loop(0, 2, 0, 0, 1'b1, 1'b1, "R9 link source");
        do_loop(2, 1, 3, 1, 1'b1, 1'b0, "R9 linked channel");

        // R9: link disabled, nothing follows
        set_cfg(3, 0, 0, 1, 1, 1, 0);
        @(negedge clk);
        do_loop(3, 1, 0, 0, 1'b1, 1'b1, "R9 no link");
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            check(!bus_rd && !bus_wr && ch_active == '0, "R9 no link quiet",
                  {bus_rd, bus_wr, ch_active}, 0);
        end

        // R10: simultaneous requests on channels 3 and 2; channel 2 first
        set_cfg(2, 0, 0, 0, 1, 1, 0);
        set_cfg(3, 2, 0, 0, 1, 1, 0);
        start_set = 4'b1100;
        @(negedge clk);
        start_set = '0;
        do_loop(2, 1, 0, 0, 1'b1, 1'b0, "R10 lower index first");
        do_loop(3, 1, 2, 0, 1'b1, 1'b0, "R10 held request");

        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule